// File: doc/BRIEF.md
# Claim/Complete Platform Interrupt Controller

This block holds the register state of a platform interrupt controller that serves `NSRC` level-sensitive interrupt sources and `NCTX` target contexts. Each context stands for one hart running at one privilege level. Firmware reaches the block through a 32-bit register port that accepts word-aligned accesses and completes each one in a single cycle. The port maps four windows:

- a priority word for each source;
- read-only pending words;
- enable words for each context;
- a two-word block for each context, holding its threshold and its claim/complete register.

A source that is seen high sets a sticky pending bit. Each context has its own winner selector. The selector picks the pending, enabled, unclaimed source whose priority is strictly above that context's threshold. The context's interrupt line is high while such a source exists.

Software claims an interrupt by reading the claim register. The read returns the winning source ID and, in the same cycle, moves that source from pending to claimed. While a source is claimed it is hidden from every context. Software ends the service by writing the source ID back to the same register. The priority range is set by the parameter `NUM_PRIO`:

- When `NUM_PRIO+1` is a power of two, priority and threshold writes keep only the legal low-order value.
- Otherwise, a write of an out-of-range value is dropped.

Top module: `irq_claim_ctrl`

## Requirements
- R1: After reset, all of the following are zero: every priority, threshold, pending bit, claimed bit and enable bit, every `irq_o` line, `rdata_o` and `err_o`.
- R2: The priority of source i is at byte offset PRIO_BASE + 4*i and reads back the stored value. A write to the priority of source 0 is dropped, and that priority always reads 0.
- R3: When NUM_PRIO+1 is a power of two, a priority or threshold write stores the written value modulo (NUM_PRIO+1). With the default NUM_PRIO=7, writing 0xE stores 6 and writing 9 stores 1.
- R4: When NUM_PRIO+1 is not a power of two, a priority or threshold write with a value above NUM_PRIO leaves the old value in place. A write of a value at or below NUM_PRIO is stored.
- R5: A source input sampled high at a clock edge sets its pending bit. A low input never clears it, and source 0 never becomes pending. Pending word w is read at PEND_BASE + 4*w, with bit j holding source 32*w+j. A write to this window changes nothing and raises no error.
- R6: Enable word w of context c is at EN_BASE + c*EN_STRIDE + 4*w, with bit j enabling source 32*w+j. Bits for sources that do not exist read 0.
- R7: In the block of context c at CTX_BASE + c*CTX_STRIDE, offset 0 is the threshold and offset 4 is claim/complete.
- R8: `irq_o[c]` is high exactly when some source is pending, enabled for c, not claimed, and has a priority strictly greater than the threshold of c. The line follows the state one cycle after the edge that changed it.
- R9: A claim read returns the ID of the highest-priority eligible source for that context, taking the lowest ID on a tie. It returns 0 when no source is eligible. The value appears on `rdata_o` after the access edge.
- R10: A claim read that returns a non-zero ID clears that source's pending bit and sets its claimed bit at the same edge. A claimed source is excluded from every context.
- R11: A write to claim/complete with a value below NSRC clears that source's claimed bit. A value at or above NSRC is ignored, including when its low bits match a claimed source.
- R12: When a claim read and a high input on the claimed source fall in the same cycle, the source's pending bit stays set.
- R13: Each of the following is invalid: a misaligned address, an unmapped address, an enable word index at or beyond ceil(NSRC/32), and a context offset other than 0 or 4. An invalid read returns 0, an invalid write changes nothing, and `err_o` is high for exactly the one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Level interrupt inputs, bit k is source k |
| req_i | input | 1 | Register access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered at the access edge, 0 otherwise |
| err_o | output | 1 | One-cycle pulse after an access to an invalid address |
| irq_o | output | NCTX | Interrupt request per context |

## Verification
The bench covers the tie-break between equal priorities. A selector that used greater-or-equal, or scanned in the wrong direction, would hand out the higher ID first. It covers a completion value whose low bits alias a claimed source; a design that truncated the value would release the wrong source. It raises a source in the very cycle it is claimed; a design that applied the clear after the set would lose that event. It also probes the threshold at equality, enable words beyond the last valid one, and a second instance in drop-if-illegal priority mode, where masking instead of ignoring would show up as a changed readback.

// File: rtl/icc_pkg.sv
package icc_pkg;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PRIO,
    RG_PEND,
    RG_EN,
    RG_THR,
    RG_CLAIM
  } icc_region_e;

  // true when a lies in [base, base+span)
  function automatic logic in_window(logic [31:0] a, logic [31:0] base, logic [31:0] span);
    return (a >= base) && ((a - base) < span);
  endfunction

  // number of 32-bit words that hold n bits
  function automatic int unsigned words_for(int unsigned n);
    return (n + 31) / 32;
  endfunction

  // true when n+1 is a power of two
  function automatic bit all_ones(int unsigned n);
    return ((n + 1) & n) == 0;
  endfunction

endpackage

// File: rtl/icc_decode.sv
module icc_decode
  import icc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned NSRC       = 40,
  parameter int unsigned NCTX       = 2,
  parameter int unsigned PRIO_BASE  = 32'h0000_0000,
  parameter int unsigned PEND_BASE  = 32'h0000_1000,
  parameter int unsigned EN_BASE    = 32'h0000_2000,
  parameter int unsigned EN_STRIDE  = 32'h0000_0080,
  parameter int unsigned CTX_BASE   = 32'h0020_0000,
  parameter int unsigned CTX_STRIDE = 32'h0000_1000,
  localparam int unsigned NWORDS    = words_for(NSRC),
  localparam int unsigned SRC_W     = $clog2(NSRC),
  localparam int unsigned WORD_W    = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int unsigned CTX_W     = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output icc_region_e       region_o,
  output logic [SRC_W-1:0]  src_idx_o,
  output logic [WORD_W-1:0] word_idx_o,
  output logic [CTX_W-1:0]  ctx_idx_o
);

  localparam logic [31:0] PRIO_SPAN = 32'(4 * NSRC);
  localparam logic [31:0] PEND_SPAN = 32'(4 * NWORDS);
  localparam logic [31:0] EN_SPAN   = 32'(NCTX * EN_STRIDE);
  localparam logic [31:0] CTX_SPAN  = 32'(NCTX * CTX_STRIDE);
  localparam int unsigned EN_SH     = $clog2(EN_STRIDE);
  localparam int unsigned CTX_SH    = $clog2(CTX_STRIDE);
  localparam logic [31:0] EN_MASK   = 32'(EN_STRIDE - 1);
  localparam logic [31:0] CTX_MASK  = 32'(CTX_STRIDE - 1);

  logic [31:0] a32;
  logic [31:0] off_p, off_q, off_e, off_c;
  logic [31:0] en_word;

  assign a32     = 32'(addr_i);
  assign off_p   = a32 - PRIO_BASE;
  assign off_q   = a32 - PEND_BASE;
  assign off_e   = a32 - EN_BASE;
  assign off_c   = a32 - CTX_BASE;
  assign en_word = (off_e & EN_MASK) >> 2;

  always_comb begin
    region_o   = RG_NONE;
    src_idx_o  = '0;
    word_idx_o = '0;
    ctx_idx_o  = '0;
    if (a32[1:0] != 2'b00) begin
      region_o = RG_NONE;
    end else if (in_window(a32, PRIO_BASE, PRIO_SPAN)) begin
      region_o  = RG_PRIO;
      src_idx_o = SRC_W'(off_p >> 2);
    end else if (in_window(a32, PEND_BASE, PEND_SPAN)) begin
      region_o   = RG_PEND;
      word_idx_o = WORD_W'(off_q >> 2);
    end else if (in_window(a32, EN_BASE, EN_SPAN)) begin
      ctx_idx_o = CTX_W'(off_e >> EN_SH);
      if (en_word < NWORDS) begin
        region_o   = RG_EN;
        word_idx_o = WORD_W'(en_word);
      end
    end else if (in_window(a32, CTX_BASE, CTX_SPAN)) begin
      ctx_idx_o = CTX_W'(off_c >> CTX_SH);
      if ((off_c & CTX_MASK) == 32'd0)      region_o = RG_THR;
      else if ((off_c & CTX_MASK) == 32'd4) region_o = RG_CLAIM;
    end
  end

endmodule

// File: rtl/icc_winner.sv
module icc_winner #(
  parameter int unsigned NSRC   = 40,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned SRC_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]             cand_i,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]           thr_i,
  output logic [SRC_W-1:0]            id_o
);

  logic [PRIO_W-1:0] best_p;

  // strict compare while scanning upward: ties keep the lower ID
  always_comb begin
    best_p = thr_i;
    id_o   = '0;
    for (int i = 1; i < NSRC; i++) begin
      if (cand_i[i] && (prio_i[i] > best_p)) begin
        best_p = prio_i[i];
        id_o   = SRC_W'(i);
      end
    end
  end

endmodule

// File: rtl/icc_pending.sv
module icc_pending #(
  parameter int unsigned NSRC   = 40,
  localparam int unsigned SRC_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_i,
  input  logic             take_i,
  input  logic [SRC_W-1:0] take_id_i,
  input  logic             free_i,
  input  logic [SRC_W-1:0] free_id_i,
  output logic [NSRC-1:0]  pend_o,
  output logic [NSRC-1:0]  clm_o
);

  logic [NSRC-1:0] take_mask, free_mask, src_eff;

  always_comb begin
    take_mask = '0;
    free_mask = '0;
    if (take_i) take_mask[take_id_i] = 1'b1;
    if (free_i) free_mask[free_id_i] = 1'b1;
  end

  // source 0 is reserved and never pends
  assign src_eff = src_i & ~NSRC'(1);

  // claim clears first, a concurrent input sets afterwards
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= '0;
      clm_o  <= '0;
    end else begin
      pend_o <= (pend_o & ~take_mask) | src_eff;
      clm_o  <= (clm_o | take_mask) & ~free_mask;
    end
  end

  for (genvar k = 1; k < NSRC; k++) begin : g_chk
    AST_SRC_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      src_i[k] |=> pend_o[k]); // R5
  end

  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !src_i[take_id_i]) |=> (!pend_o[$past(take_id_i)] && clm_o[$past(take_id_i)])); // R10

  AST_RACE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && src_i[take_id_i]) |=> (pend_o[$past(take_id_i)] && clm_o[$past(take_id_i)])); // R12

  AST_FREE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    free_i |=> !clm_o[$past(free_id_i)]); // R11

endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl
  import icc_pkg::*;
#(
  parameter int unsigned NSRC       = 40,
  parameter int unsigned NCTX       = 2,
  parameter int unsigned NUM_PRIO   = 7,
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned PRIO_BASE  = 32'h0000_0000,
  parameter int unsigned PEND_BASE  = 32'h0000_1000,
  parameter int unsigned EN_BASE    = 32'h0000_2000,
  parameter int unsigned EN_STRIDE  = 32'h0000_0080,
  parameter int unsigned CTX_BASE   = 32'h0020_0000,
  parameter int unsigned CTX_STRIDE = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              err_o,
  output logic [NCTX-1:0]   irq_o
);

  localparam int unsigned NWORDS    = words_for(NSRC);
  localparam int unsigned PAD_W     = NWORDS * 32;
  localparam int unsigned SRC_W     = $clog2(NSRC);
  localparam int unsigned WORD_W    = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int unsigned CTX_W     = (NCTX > 1) ? $clog2(NCTX) : 1;
  localparam int unsigned PRIO_W    = $clog2(NUM_PRIO + 1);
  localparam bit          PRIO_WARL = all_ones(NUM_PRIO);

  // legal value for a priority/threshold write
  function automatic logic [PRIO_W-1:0] fit_prio(logic [31:0] v, logic [PRIO_W-1:0] old);
    if (PRIO_WARL)          return PRIO_W'(v % 32'(NUM_PRIO + 1));
    else if (v <= NUM_PRIO) return PRIO_W'(v);
    else                    return old;
  endfunction

  icc_region_e       region;
  logic [SRC_W-1:0]  src_idx;
  logic [WORD_W-1:0] word_idx;
  logic [CTX_W-1:0]  ctx_idx;

  logic [NSRC-1:0][PRIO_W-1:0] prio_q;
  logic [NCTX-1:0][PRIO_W-1:0] thr_q;
  logic [NCTX-1:0][NSRC-1:0]   en_q;
  logic [NSRC-1:0]             pend_q, clm_q;
  logic [NCTX-1:0][SRC_W-1:0]  win_id;

  // named internal events
  logic             acc_rd, acc_wr;
  logic             claim_fire, done_fire;
  logic [SRC_W-1:0] claim_id, done_id;
  logic [PAD_W-1:0] pend_pad, en_pad, en_merge;
  logic [31:0]      rd_val;

  icc_decode #(
    .ADDR_W(ADDR_W), .NSRC(NSRC), .NCTX(NCTX),
    .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE),
    .EN_BASE(EN_BASE), .EN_STRIDE(EN_STRIDE),
    .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
  ) u_dec (
    .addr_i(addr_i), .region_o(region), .src_idx_o(src_idx),
    .word_idx_o(word_idx), .ctx_idx_o(ctx_idx)
  );

  assign acc_rd     = req_i && !we_i;
  assign acc_wr     = req_i && we_i;
  assign claim_id   = win_id[ctx_idx];
  assign claim_fire = acc_rd && (region == RG_CLAIM) && (claim_id != '0);
  assign done_fire  = acc_wr && (region == RG_CLAIM) && (wdata_i < NSRC);
  assign done_id    = SRC_W'(wdata_i);

  icc_pending #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .take_i(claim_fire), .take_id_i(claim_id),
    .free_i(done_fire), .free_id_i(done_id),
    .pend_o(pend_q), .clm_o(clm_q)
  );

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic [NSRC-1:0] cand;
    assign cand = pend_q & ~clm_q & en_q[c];

    icc_winner #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_win (
      .cand_i(cand), .prio_i(prio_q), .thr_i(thr_q[c]), .id_o(win_id[c])
    );

    assign irq_o[c] = (win_id[c] != '0);

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[c] |-> ((pend_q & ~clm_q & en_q[c]) != '0)); // R8
  end

  assign pend_pad = PAD_W'(pend_q);
  assign en_pad   = PAD_W'(en_q[ctx_idx]);

  always_comb begin
    en_merge = en_pad;
    en_merge[32*word_idx +: 32] = wdata_i;
  end

  always_comb begin
    case (region)
      RG_PRIO:  rd_val = 32'(prio_q[src_idx]);
      RG_PEND:  rd_val = pend_pad[32*word_idx +: 32];
      RG_EN:    rd_val = en_pad[32*word_idx +: 32];
      RG_THR:   rd_val = 32'(thr_q[ctx_idx]);
      RG_CLAIM: rd_val = 32'(claim_id);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      thr_q  <= '0;
      en_q   <= '0;
    end else if (acc_wr) begin
      if (region == RG_PRIO && src_idx != '0)
        prio_q[src_idx] <= fit_prio(wdata_i, prio_q[src_idx]);
      if (region == RG_THR)
        thr_q[ctx_idx] <= fit_prio(wdata_i, thr_q[ctx_idx]);
      if (region == RG_EN)
        en_q[ctx_idx] <= NSRC'(en_merge);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= acc_rd ? rd_val : '0;
      err_o   <= req_i && (region == RG_NONE);
    end
  end

  AST_SRC0_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && region == RG_PRIO && src_idx == '0) |=> $stable(prio_q)); // R2

  AST_ILLEGAL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && region == RG_PRIO && !PRIO_WARL && wdata_i > NUM_PRIO) |=> $stable(prio_q)); // R4

  AST_CLAIM_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    claim_fire |-> (pend_q[claim_id] && !clm_q[claim_id] && en_q[ctx_idx][claim_id])); // R9

  AST_ERR_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(req_i)); // R13

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !$past(req_i, 1)) |-> 1'b0); // R13

endmodule

// File: tb/sim_irq_claim_ctrl.sv
`timescale 1ns/1ps
module sim_irq_claim_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] src = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [23:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [1:0]  irq;

  // second instance: NUM_PRIO=5 selects drop-if-illegal
  logic [3:0]  src1 = '0;
  logic        req1 = 1'b0, we1 = 1'b0;
  logic [23:0] addr1 = '0;
  logic [31:0] wdata1 = '0;
  logic [31:0] rdata1;
  logic        err1;
  logic [0:0]  irq1;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_claim_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .irq_o(irq)
  );

  irq_claim_ctrl #(.NSRC(4), .NCTX(1), .NUM_PRIO(5)) u1 (
    .clk(clk), .rst_n(rst_n), .src_i(src1), .req_i(req1), .we_i(we1),
    .addr_i(addr1), .wdata_i(wdata1), .rdata_o(rdata1), .err_o(err1), .irq_o(irq1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic acc_src(input logic [23:0] a, input logic [39:0] m);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; src = m;
    @(negedge clk);
    req = 1'b0; src = '0;
  endtask

  task automatic acc1(input logic w, input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    req1 = 1'b1; we1 = w; addr1 = a; wdata1 = d;
    @(negedge clk);
    req1 = 1'b0; we1 = 1'b0;
  endtask

  task automatic pulse(input logic [39:0] m);
    @(negedge clk);
    src = m;
    @(negedge clk);
    src = '0;
  endtask

  // {req#, we, addr, wdata, expected rdata, expected err}
  localparam int NV = 25;
  localparam logic [93:0] VEC [NV] = '{
    {4'd2,  1'b1, 24'h00000C, 32'h5,        32'h0,        1'b0}, // R2 prio3
    {4'd2,  1'b0, 24'h00000C, 32'h0,        32'h5,        1'b0}, // R2
    {4'd3,  1'b1, 24'h00000C, 32'hE,        32'h0,        1'b0}, // R3 masked
    {4'd3,  1'b0, 24'h00000C, 32'h0,        32'h6,        1'b0}, // R3
    {4'd2,  1'b1, 24'h000000, 32'h3,        32'h0,        1'b0}, // R2 src0
    {4'd2,  1'b0, 24'h000000, 32'h0,        32'h0,        1'b0}, // R2
    {4'd3,  1'b1, 24'h200000, 32'h9,        32'h0,        1'b0}, // R3 thr0
    {4'd7,  1'b0, 24'h200000, 32'h0,        32'h1,        1'b0}, // R7
    {4'd6,  1'b1, 24'h002000, 32'hFFFFFFFF, 32'h0,        1'b0}, // R6
    {4'd6,  1'b0, 24'h002000, 32'h0,        32'hFFFFFFFF, 1'b0}, // R6
    {4'd6,  1'b1, 24'h002004, 32'hFFFFFFFF, 32'h0,        1'b0}, // R6
    {4'd6,  1'b0, 24'h002004, 32'h0,        32'h000000FF, 1'b0}, // R6
    {4'd13, 1'b1, 24'h002008, 32'h1,        32'h0,        1'b1}, // R13
    {4'd13, 1'b0, 24'h002008, 32'h0,        32'h0,        1'b1}, // R13
    {4'd6,  1'b0, 24'h002080, 32'h0,        32'h0,        1'b0}, // R6 ctx1
    {4'd13, 1'b0, 24'h200008, 32'h0,        32'h0,        1'b1}, // R13
    {4'd13, 1'b0, 24'h00000E, 32'h0,        32'h0,        1'b1}, // R13
    {4'd13, 1'b0, 24'h003000, 32'h0,        32'h0,        1'b1}, // R13
    {4'd5,  1'b1, 24'h001000, 32'hFFFFFFFF, 32'h0,        1'b0}, // R5
    {4'd5,  1'b0, 24'h001000, 32'h0,        32'h0,        1'b0}, // R5
    {4'd9,  1'b0, 24'h200004, 32'h0,        32'h0,        1'b0}, // R9
    {4'd7,  1'b1, 24'h201000, 32'h3,        32'h0,        1'b0}, // R7 thr1
    {4'd7,  1'b0, 24'h201000, 32'h0,        32'h3,        1'b0}, // R7
    {4'd11, 1'b1, 24'h200004, 32'd100,      32'h0,        1'b0}, // R11
    {4'd2,  1'b0, 24'h00000C, 32'h0,        32'h6,        1'b0}  // R2
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", 32'(irq), 32'h0);
    chk("R1 rdata after reset", rdata, 32'h0);
    chk("R1 err after reset", 32'(err), 32'h0);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][89], VEC[i][88:65], VEC[i][64:33]);
      if (!VEC[i][89])
        chk($sformatf("R%0d vec%0d rdata", VEC[i][93:90], i), rdata, VEC[i][32:1]);
      chk($sformatf("R%0d vec%0d err", VEC[i][93:90], i), 32'(err), 32'(VEC[i][0]));
    end

    // sticky pending and interrupt line
    pulse(40'h8);
    acc(1'b0, 24'h001000, 0);
    chk("R5 pend after pulse", rdata, 32'h8);
    chk("R8 irq ctx0 only", 32'(irq), 32'h1);

    // priority order, tie-break, claim side effects
    acc(1'b1, 24'h000014, 6);
    acc(1'b1, 24'h000084, 7);
    pulse(40'h02_0000_0021);
    acc(1'b0, 24'h001000, 0);
    chk("R5 pend word0 src0 ignored", rdata, 32'h28);
    acc(1'b0, 24'h001004, 0);
    chk("R5 pend word1", rdata, 32'h2);
    acc(1'b0, 24'h200004, 0);
    chk("R9 claim highest", rdata, 32'd33);
    acc(1'b0, 24'h001004, 0);
    chk("R10 claim clears pending", rdata, 32'h0);
    acc(1'b0, 24'h200004, 0);
    chk("R9 tie lowest id", rdata, 32'd3);
    acc(1'b0, 24'h200004, 0);
    chk("R9 next claim", rdata, 32'd5);
    acc(1'b0, 24'h200004, 0);
    chk("R9 claim empty", rdata, 32'd0);
    chk("R10 irq low when all claimed", 32'(irq), 32'h0);

    // claimed source masked until completion
    pulse(40'h8);
    acc(1'b0, 24'h001000, 0);
    chk("R10 repend while claimed", rdata, 32'h8);
    chk("R10 irq masked by claim", 32'(irq), 32'h0);
    acc(1'b1, 24'h200004, 3);
    chk("R11 complete releases", 32'(irq), 32'h1);

    // threshold at equality
    acc(1'b1, 24'h200000, 6);
    chk("R8 prio equal to threshold", 32'(irq), 32'h0);
    acc(1'b1, 24'h200000, 5);
    chk("R8 prio above threshold", 32'(irq), 32'h1);
    acc(1'b1, 24'h200000, 1);

    // second context
    acc(1'b1, 24'h002080, 32'h8);
    chk("R8 both contexts", 32'(irq), 32'h3);
    acc(1'b0, 24'h201004, 0);
    chk("R9 claim ctx1", rdata, 32'd3);
    chk("R10 claim hides from all", 32'(irq), 32'h0);

    // oversize completion aliasing a claimed ID
    pulse(40'h20);
    chk("R10 src5 still claimed", 32'(irq), 32'h0);
    acc(1'b1, 24'h200004, 69);
    chk("R11 oversize complete ignored", 32'(irq), 32'h0);
    acc(1'b1, 24'h200004, 5);
    chk("R11 complete src5", 32'(irq), 32'h1);

    // claim and new level in one cycle
    acc_src(24'h200004, 40'h20);
    chk("R12 claim value", rdata, 32'd5);
    acc(1'b0, 24'h001000, 0);
    chk("R12 pending kept", rdata, 32'h20);
    chk("R12 irq held off by claim", 32'(irq), 32'h0);
    acc(1'b1, 24'h200004, 5);
    chk("R12 event survives", 32'(irq), 32'h1);

    // drop-if-illegal mode on the second instance
    acc1(1'b1, 24'h000004, 6);
    acc1(1'b0, 24'h000004, 0);
    chk("R4 illegal prio dropped", rdata1, 32'h0);
    acc1(1'b1, 24'h000004, 5);
    acc1(1'b0, 24'h000004, 0);
    chk("R4 legal prio stored", rdata1, 32'h5);
    acc1(1'b1, 24'h000004, 7);
    acc1(1'b0, 24'h000004, 0);
    chk("R4 old prio kept", rdata1, 32'h5);
    acc1(1'b1, 24'h200000, 2);
    acc1(1'b1, 24'h200000, 6);
    acc1(1'b0, 24'h200000, 0);
    chk("R4 threshold kept", rdata1, 32'h2);

    // reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 irq in reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    acc(1'b0, 24'h00000C, 0);
    chk("R1 prio cleared", rdata, 32'h0);
    acc(1'b0, 24'h001000, 0);
    chk("R1 pending cleared", rdata, 32'h0);
    acc(1'b0, 24'h200000, 0);
    chk("R1 threshold cleared", rdata, 32'h0);
    acc(1'b0, 24'h002000, 0);
    chk("R1 enable cleared", rdata, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule